// File: doc/BRIEF.md
# Output Code Slew Limiter

This block sits between a converter channel's requested target code and the code that actually drives the converter core. With limiting switched off, the output code copies the target on the next clock. With limiting switched on, the output code walks toward the target in fixed increments. Each increment is applied on an internal update tick whose period is derived from the system clock frequency and a rate code. The last increment is clipped so that the output lands exactly on the target.

A 13-bit configuration word supplies three things: the enable, the increment size code and the update rate code. A change of target in the middle of a ramp redirects the ramp from wherever the output currently stands. A busy flag reports that the output has not yet reached the target.

Top module: `slew_limiter`

## Requirements
- R1: While reset is asserted, the output code is cleared to zero, and it stays zero after reset while the target is zero and limiting is off.
- R2: When configuration bit 12 is 0, the output code equals the target sampled at the previous clock edge, and this includes the case where limiting is dropped in the middle of a ramp.
- R3: The increment size code is configuration bits 3:0. Codes 0 to 8 give an increment of 2^code LSBs (1 up to 256), and codes 9 to 15 also give 256 LSBs. Bit 3 is shared with the rate field.
- R4: The rate code is configuration bits 6:3. The update period in clocks is CLK_HZ divided by the rate in updates per second. Codes 0 to 15 give rates of 64000, 32000, 16000, 8000, 4000, 2000, 1000, 500, 250, 125, 64, 32, 16, 8, 4 and 0.5, so code 15 has a period of 2*CLK_HZ clocks.
- R5: With limiting on, the target applied before clock edge 1 and the output idle, the first increment appears after edge P. Later increments follow every P edges, where P is the update period.
- R6: When the remaining distance is smaller than the increment, the output is set equal to the target, and it never passes beyond the target.
- R7: Ramps toward a lower target step downward by the same increments as upward ramps.
- R8: busy_o is high exactly when the output code differs from the target code.
- R9: A new target that arrives during a ramp redirects the ramp from the current output code, with no restart of the output.
- R10: Between update ticks, and whenever the output equals the target, the output code holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| target_i | input | CODE_W | Requested code for the channel |
| cfg_i | input | 13 | Limiter configuration: bit 12 enable, bits 6:3 rate code, bits 3:0 increment code |
| code_o | output | CODE_W | Code presented to the converter core |
| busy_o | output | 1 | Output code has not reached the target |

## Verification
The bench builds the block with a 16-bit code and CLK_HZ set to 64000. With that setting the fastest rate code updates every clock, rate codes 1 and 2 give periods of 2 and 4 clocks, and the slowest code gives exactly 128000 clocks. Tick spacing can therefore be checked edge by edge, and the 2-second code can be run out in full inside the run. The 16-bit width leaves room for 256-LSB increments in both directions, with clipping at the end of each ramp.

// File: rtl/slew_pkg.sv
package slew_pkg;

   localparam int unsigned CFG_W      = 13;
   localparam int unsigned EN_BIT     = 12;
   localparam int unsigned STEP_LO    = 0;
   localparam int unsigned RATE_LO    = 3;
   localparam int unsigned FIELD_W    = 4;
   localparam int unsigned N_RATES    = 16;
   localparam int unsigned MAX_SHIFT  = 8;

   // Update rate in half-updates per second (twice the rate), so the
   // slowest code (0.5/s) stays an integer.
   function automatic int unsigned rate_x2(input int unsigned code);
      case (code)
         0:       return 128000;
         1:       return 64000;
         2:       return 32000;
         3:       return 16000;
         4:       return 8000;
         5:       return 4000;
         6:       return 2000;
         7:       return 1000;
         8:       return 500;
         9:       return 250;
         10:      return 128;
         11:      return 64;
         12:      return 32;
         13:      return 16;
         14:      return 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/slew_tick.sv
module slew_tick #(
   parameter int unsigned CLK_HZ = 50_000_000
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          run,
   input  logic [slew_pkg::FIELD_W-1:0]  rate_code,
   output logic                          tick
);
   import slew_pkg::*;

   localparam int unsigned MAX_PERIOD = 2 * CLK_HZ;
   localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);

   logic [CNT_W-1:0] period_tab [N_RATES];
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt_q;

   for (genvar g = 0; g < N_RATES; g++) begin : g_period
      localparam int unsigned PER = MAX_PERIOD / rate_x2(g);
      assign period_tab[g] = CNT_W'(PER);
   end

   assign period = period_tab[rate_code];
   assign tick   = run && (cnt_q >= period - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // After a tick the counter restarts, so a longer period cannot tick twice in a row
   assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
      (tick && period > CNT_W'(1)) |=> (!tick || period == CNT_W'(1)));

   // Counter never runs while idle
   assert_idle_clear_R10: assert property (@(posedge clk) disable iff (rst)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/slew_step.sv
module slew_step #(
   parameter int unsigned CODE_W = 16
) (
   input  logic [CODE_W-1:0]             cur,
   input  logic [CODE_W-1:0]             tgt,
   input  logic [slew_pkg::FIELD_W-1:0]  step_code,
   output logic [CODE_W-1:0]             nxt
);
   import slew_pkg::*;

   logic [FIELD_W-1:0] shamt;
   logic [CODE_W-1:0]  step;
   logic [CODE_W-1:0]  up_gap;
   logic [CODE_W-1:0]  dn_gap;

   always_comb begin
      shamt  = (step_code >= FIELD_W'(MAX_SHIFT)) ? FIELD_W'(MAX_SHIFT) : step_code;
      step   = CODE_W'(1) << shamt;
      up_gap = tgt - cur;
      dn_gap = cur - tgt;
      if (tgt == cur) begin
         nxt = cur;
      end else if (tgt > cur) begin
         nxt = (up_gap >= step) ? cur + step : tgt;
      end else begin
         nxt = (dn_gap >= step) ? cur - step : tgt;
      end
   end

endmodule

// File: rtl/slew_limiter.sv
module slew_limiter #(
   parameter int unsigned CODE_W = 16,
   parameter int unsigned CLK_HZ = 50_000_000
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [CODE_W-1:0]          target_i,
   input  logic [slew_pkg::CFG_W-1:0] cfg_i,
   output logic [CODE_W-1:0]          code_o,
   output logic                       busy_o
);
   import slew_pkg::*;

   if (CODE_W < MAX_SHIFT + 1) begin : g_bad_width
      $error("CODE_W must hold the largest increment");
   end
   if (CLK_HZ < 64000) begin : g_bad_clk
      $error("CLK_HZ must be at least the fastest update rate");
   end

   logic               enable;
   logic [FIELD_W-1:0] step_code;
   logic [FIELD_W-1:0] rate_code;
   logic               tick;
   logic [CODE_W-1:0]  step_next;
   logic [CODE_W-1:0]  code_q;

   assign enable    = cfg_i[EN_BIT];
   assign step_code = cfg_i[STEP_LO +: FIELD_W];
   assign rate_code = cfg_i[RATE_LO +: FIELD_W];
   assign busy_o    = (code_q != target_i);
   assign code_o    = code_q;

   slew_tick #(.CLK_HZ(CLK_HZ)) u_tick (
      .clk       (clk),
      .rst       (rst),
      .run       (enable && busy_o),
      .rate_code (rate_code),
      .tick      (tick)
   );

   slew_step #(.CODE_W(CODE_W)) u_step (
      .cur       (code_q),
      .tgt       (target_i),
      .step_code (step_code),
      .nxt       (step_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
      end else if (!enable) begin
         code_q <= target_i;
      end else if (tick) begin
         code_q <= step_next;
      end
   end

   assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
      !enable |=> (code_o == $past(target_i)));

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (enable && !tick) |=> (code_o == $past(code_o)));

   assert_no_overshoot_up_R6: assert property (@(posedge clk) disable iff (rst)
      (enable && code_o < target_i) |=> (code_o <= $past(target_i) && code_o >= $past(code_o)));

   assert_no_overshoot_dn_R7: assert property (@(posedge clk) disable iff (rst)
      (enable && code_o > target_i) |=> (code_o >= $past(target_i) && code_o <= $past(code_o)));

   assert_settled_R8: assert property (@(posedge clk) disable iff (rst)
      (enable && !busy_o) |=> (code_o == $past(code_o)));

endmodule

// File: tb/slew_limiter_bench.sv
module slew_limiter_bench;

   localparam int unsigned CODE_W = 16;
   localparam int unsigned CLK_HZ = 64000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [CODE_W-1:0] target_i = '0;
   logic [12:0]       cfg_i = '0;
   logic [CODE_W-1:0] code_o;
   logic              busy_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   slew_limiter #(.CODE_W(CODE_W), .CLK_HZ(CLK_HZ)) u_slew_limiter (
      .clk      (clk),
      .rst      (rst),
      .target_i (target_i),
      .cfg_i    (cfg_i),
      .code_o   (code_o),
      .busy_o   (busy_o)
   );

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [CODE_W-1:0] exp_code, input logic exp_busy);
      checks++;
      if (code_o !== exp_code || busy_o !== exp_busy) begin
         errors++;
         $display("FAIL %s code=%h busy=%b expected code=%h busy=%b",
                  req, code_o, busy_o, exp_code, exp_busy);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; cfg_i = '0; target_i = '0;
      edges(3);
      check("R1 during reset", 16'h0000, 1'b0);
      rst = 1'b0;
      edges(2);
      check("R1 after reset", 16'h0000, 1'b0);
   endtask

   task automatic t_bypass;
      cfg_i = 13'h0000; target_i = 16'h1234;
      edges(1);
      check("R2 bypass follows target", 16'h1234, 1'b0);
   endtask

   task automatic t_fast_ramp;
      cfg_i = 13'h1002; target_i = 16'h123E;    // increment 4, period 1
      edges(1); check("R5 R8 first step period 1", 16'h1238, 1'b1);
      edges(1); check("R5 second step", 16'h123C, 1'b1);
      edges(1); check("R6 R8 clipped final step", 16'h123E, 1'b0);
      edges(3); check("R10 holds at target", 16'h123E, 1'b0);
   endtask

   task automatic t_slow_rate;
      cfg_i = 13'h1010; target_i = 16'h1241;    // increment 1, rate code 2 -> period 4
      edges(3); check("R4 R5 no step before edge 4", 16'h123E, 1'b1);
      edges(1); check("R4 R5 step at edge 4", 16'h123F, 1'b1);
      edges(4); check("R5 next step 4 edges later", 16'h1240, 1'b1);
      cfg_i = 13'h0000;
      edges(1); check("R2 disable mid ramp jumps to target", 16'h1241, 1'b0);
   endtask

   task automatic t_down_256;
      cfg_i = 13'h1008; target_i = 16'h0FE9;    // increment code 8, rate code 1 -> period 2
      edges(1); check("R4 period 2 no step at edge 1", 16'h1241, 1'b1);
      edges(1); check("R3 R7 down 256", 16'h1141, 1'b1);
      edges(2); check("R7 down 256 again", 16'h1041, 1'b1);
      edges(2); check("R6 R7 clipped down", 16'h0FE9, 1'b0);
   endtask

   task automatic t_big_code;
      cfg_i = 13'h100C; target_i = 16'h1115;    // increment code 12 -> 256, rate code 1
      edges(2); check("R3 code above 8 gives 256", 16'h10E9, 1'b1);
      edges(2); check("R6 clip after large step", 16'h1115, 1'b0);
   endtask

   task automatic t_retarget;
      cfg_i = 13'h1002; target_i = 16'h1179;
      edges(3); check("R9 ramp before redirect", 16'h1121, 1'b1);
      target_i = 16'h1115;
      edges(1); check("R9 redirected from current code", 16'h111D, 1'b1);
      edges(2); check("R9 reaches new target", 16'h1115, 1'b0);
   endtask

   task automatic t_slowest;
      cfg_i = 13'h1078; target_i = 16'h1116;    // rate code 15 -> 2*CLK_HZ clocks
      edges(127999); check("R4 code 15 no step before 2 s", 16'h1115, 1'b1);
      edges(1);      check("R4 code 15 step at 2 s", 16'h1116, 1'b0);
   endtask

   initial begin
      t_reset();
      t_bypass();
      t_fast_ramp();
      t_slow_rate();
      t_down_256();
      t_big_code();
      t_retarget();
      t_slowest();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (190000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired code=%h busy=%b expected completion", code_o, busy_o);
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule